// File: doc/BRIEF.md
# One-of-Four Quaternary Gate Set

This block performs logic directly on quaternary digits in one-hot form, so that a mixed-radix datapath never has to split a digit back into two binary wires before it can use it. Each digit travels on four rails. Exactly one rail is high for a data value, and all four rails are low for the spacer that separates two data words in a return-to-zero handshake. A set of `LANES` identical lanes is provided. Each lane holds two gates.

The bitwise gate takes two digits A and B. It reads each digit as a pair of bits and applies one 2-input operation to the low bits of both digits and, separately, to the high bits. The two result bits form the output digit. The quaternary-to-binary gate takes one digit, applies the same operation to that digit's own high and low bits, and emits a single dual-rail bit. This gives the same result as a splitter followed by an ordinary binary gate. The `OP_SEL` parameter picks AND, OR or XOR for every gate in the set.

Both gates hold a spacer output until every operand they need carries valid data, and they drop back to spacer as soon as any operand does. An operand with more than one hot rail is not a legal code. It forces a spacer output and raises that gate's error flag.

Top module: `qgate_set`

## Requirements
- R1: A digit of value v (0..3) is encoded with only rail v high: 0001=0, 0010=1, 0100=2, 1000=3. Bit 1 of the value is the digit's high bit and bit 0 is its low bit. All-zero is the spacer.
- R2: When both A and B of a lane are valid, the output digit has high bit (A high op B high) and low bit (A low op B low). With the default OP_SEL=2 the operation is XOR; OP_SEL=0 selects AND and OP_SEL=1 selects OR.
- R3: If either operand of a lane's bitwise gate is a spacer, that lane's output digit is a spacer, whatever the other operand carries.
- R4: For a valid input digit, the quaternary-to-binary output is (high bit op low bit) in dual-rail form: 01 for 0 and 10 for 1.
- R5: A spacer on the quaternary-to-binary input gives output 00, and that lane's error flag stays low.
- R6: A multi-hot code (two or more rails high) on A or B forces the lane's output digit to spacer and sets that lane's bw_err. Otherwise bw_err is low.
- R7: A multi-hot code on the quaternary-to-binary input forces output 00 and sets that lane's qb_err. Otherwise qb_err is low.
- R8: Every output always has at most one rail high, and it has exactly one high rail whenever all of its operands are valid.
- R9: Each lane's outputs depend only on that lane's own input digits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_dig | input | 4*LANES | First operand digits of the bitwise gates, lane k at bits [4k+3:4k] |
| b_dig | input | 4*LANES | Second operand digits of the bitwise gates |
| q_dig | output | 4*LANES | Result digits of the bitwise gates |
| bw_err | output | LANES | Per-lane illegal-code flag of the bitwise gate |
| c_dig | input | 4*LANES | Input digits of the quaternary-to-binary gates |
| y_dr | output | 2*LANES | Dual-rail results, lane k at bits [2k+1:2k], 10 = 1, 01 = 0 |
| qb_err | output | LANES | Per-lane illegal-code flag of the quaternary-to-binary gate |

## Verification
All 16 valid operand pairs and all 4 valid single digits are tried on lane 0 while lane 1 is held at spacer. This separates a wrong bit pairing, such as the high bit of A being combined with the low bit of B, from a wrong operation, and it shows whether one lane leaks into the other. Directed spacer cases, with one operand valid and the other empty, distinguish a gate that waits for both operands from one that fires on a single operand. Multi-hot codes such as 0011, 0110 and 1111 show whether illegal codes are folded into a valid value instead of being trapped. A seeded random mix of valid, spacer and illegal codes across both lanes then covers the combinations the directed cases do not reach.

// File: rtl/qgate_pkg.sv
`timescale 1ns/1ps
package qgate_pkg;
   localparam int DIG_W  = 4;
   localparam int DR_W   = 2;
   localparam int OP_AND = 0;
   localparam int OP_OR  = 1;
   localparam int OP_XOR = 2;

   typedef logic [DIG_W-1:0] digit_t;
   typedef logic [DR_W-1:0]  drbit_t;

   typedef struct packed {
      logic hi;
      logic lo;
      logic valid;
      logic bad;
   } split_t;
endpackage

// File: rtl/q4_split.sv
`timescale 1ns/1ps
module q4_split
   import qgate_pkg::*;
(
   input  digit_t dig,
   output split_t info
);
   logic [2:0] hot_cnt;

   always_comb begin
      hot_cnt = '0;
      for (int i = 0; i < DIG_W; i++) begin
         hot_cnt = hot_cnt + {2'b00, dig[i]};
      end
      info.valid = (hot_cnt == 3'd1);
      info.bad   = (hot_cnt > 3'd1);
      info.hi    = info.valid & (dig[3] | dig[2]);
      info.lo    = info.valid & (dig[3] | dig[1]);
   end
endmodule

// File: rtl/q4_binop.sv
`timescale 1ns/1ps
module q4_binop
   import qgate_pkg::*;
#(
   parameter int OP_SEL = OP_XOR
) (
   input  logic x,
   input  logic y,
   output logic z
);
   generate
      if (OP_SEL == OP_AND) begin : g_and
         assign z = x & y;
      end else if (OP_SEL == OP_OR) begin : g_or
         assign z = x | y;
      end else if (OP_SEL == OP_XOR) begin : g_xor
         assign z = x ^ y;
      end else begin : g_bad_op
         $error("q4_binop: OP_SEL must be 0, 1 or 2");
         assign z = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/q4_mix.sv
`timescale 1ns/1ps
module q4_mix
   import qgate_pkg::*;
(
   input  logic   en,
   input  logic   hi,
   input  logic   lo,
   output digit_t dig
);
   always_comb begin
      dig = '0;
      for (int v = 0; v < DIG_W; v++) begin
         dig[v] = en & ({hi, lo} == v[1:0]);
      end
   end
endmodule

// File: rtl/qgate_set.sv
`timescale 1ns/1ps
module qgate_set
   import qgate_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int OP_SEL = OP_XOR
) (
   input  logic [LANES*DIG_W-1:0] a_dig,
   input  logic [LANES*DIG_W-1:0] b_dig,
   output logic [LANES*DIG_W-1:0] q_dig,
   output logic [LANES-1:0]       bw_err,
   input  logic [LANES*DIG_W-1:0] c_dig,
   output logic [LANES*DR_W-1:0]  y_dr,
   output logic [LANES-1:0]       qb_err
);
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("qgate_set: LANES must be at least 1");
      end
      if (OP_SEL < OP_AND || OP_SEL > OP_XOR) begin : g_bad_sel
         $error("qgate_set: OP_SEL out of range");
      end
   endgenerate

   genvar k;
   generate
      for (k = 0; k < LANES; k++) begin : g_lane
         split_t sa, sb, sc;
         logic   rq_hi, rq_lo, ry, both_ok;

         q4_split u_sa (.dig(a_dig[k*DIG_W +: DIG_W]), .info(sa));
         q4_split u_sb (.dig(b_dig[k*DIG_W +: DIG_W]), .info(sb));
         q4_split u_sc (.dig(c_dig[k*DIG_W +: DIG_W]), .info(sc));

         // bitwise gate: high with high, low with low
         q4_binop #(.OP_SEL(OP_SEL)) u_op_hi (.x(sa.hi), .y(sb.hi), .z(rq_hi));
         q4_binop #(.OP_SEL(OP_SEL)) u_op_lo (.x(sa.lo), .y(sb.lo), .z(rq_lo));

         assign both_ok = sa.valid & sb.valid;

         q4_mix u_mix (
            .en (both_ok),
            .hi (rq_hi),
            .lo (rq_lo),
            .dig(q_dig[k*DIG_W +: DIG_W])
         );
         assign bw_err[k] = sa.bad | sb.bad;

         // quaternary-to-binary gate: digit's own two bits
         q4_binop #(.OP_SEL(OP_SEL)) u_op_qb (.x(sc.hi), .y(sc.lo), .z(ry));
         assign y_dr[k*DR_W + 1] = sc.valid &  ry;
         assign y_dr[k*DR_W]     = sc.valid & ~ry;
         assign qb_err[k]        = sc.bad;
      end
   endgenerate
endmodule

// File: rtl/qgate_set_chk.sv
`timescale 1ns/1ps
module qgate_set_chk
   import qgate_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int OP_SEL = OP_XOR
) (
   input logic [LANES*DIG_W-1:0] a_dig,
   input logic [LANES*DIG_W-1:0] b_dig,
   input logic [LANES*DIG_W-1:0] q_dig,
   input logic [LANES-1:0]       bw_err,
   input logic [LANES*DIG_W-1:0] c_dig,
   input logic [LANES*DR_W-1:0]  y_dr,
   input logic [LANES-1:0]       qb_err
);
   always_comb begin
      for (int k = 0; k < LANES; k++) begin
         assert_q_onehot0_R8: assert ($onehot0(q_dig[k*DIG_W +: DIG_W]))
            else $error("q_dig lane %0d multi-hot", k);
         assert_y_onehot0_R8: assert ($onehot0(y_dr[k*DR_W +: DR_W]))
            else $error("y_dr lane %0d both rails", k);
         assert_bw_spacer_R3: assert (!((a_dig[k*DIG_W +: DIG_W] == '0 ||
                                         b_dig[k*DIG_W +: DIG_W] == '0) &&
                                        q_dig[k*DIG_W +: DIG_W] != '0))
            else $error("q_dig lane %0d valid with a spacer operand", k);
         assert_bw_valid_out_R8: assert (!($onehot(a_dig[k*DIG_W +: DIG_W]) &&
                                           $onehot(b_dig[k*DIG_W +: DIG_W])) ||
                                         $onehot(q_dig[k*DIG_W +: DIG_W]))
            else $error("q_dig lane %0d not one-hot for valid operands", k);
         assert_bw_err_R6: assert (!bw_err[k] || q_dig[k*DIG_W +: DIG_W] == '0)
            else $error("q_dig lane %0d valid while error flagged", k);
         assert_qb_err_R7: assert (!qb_err[k] || y_dr[k*DR_W +: DR_W] == '0)
            else $error("y_dr lane %0d valid while error flagged", k);
         assert_qb_spacer_R5: assert (c_dig[k*DIG_W +: DIG_W] != '0 ||
                                      (y_dr[k*DR_W +: DR_W] == '0 && !qb_err[k]))
            else $error("y_dr lane %0d not spacer for spacer input", k);
      end
   end
endmodule

bind qgate_set qgate_set_chk #(.LANES(LANES), .OP_SEL(OP_SEL)) u_chk (
   .a_dig (a_dig),
   .b_dig (b_dig),
   .q_dig (q_dig),
   .bw_err(bw_err),
   .c_dig (c_dig),
   .y_dr  (y_dr),
   .qb_err(qb_err)
);

// File: tb/sim_qgate_set.sv
`timescale 1ns/1ps
module sim_qgate_set;
   localparam int L = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [L*4-1:0] a_dig, b_dig, c_dig, q_dig;
   logic [L-1:0]   bw_err, qb_err;
   logic [L*2-1:0] y_dr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   qgate_set #(.LANES(L), .OP_SEL(2)) u0 (
      .a_dig (a_dig),
      .b_dig (b_dig),
      .q_dig (q_dig),
      .bw_err(bw_err),
      .c_dig (c_dig),
      .y_dr  (y_dr),
      .qb_err(qb_err)
   );

   // decode from R1: returns {bad, valid, value[1:0]}
   function automatic logic [3:0] dec(input logic [3:0] d);
      case (d)
         4'b0000: dec = 4'b0000;
         4'b0001: dec = 4'b0100;
         4'b0010: dec = 4'b0101;
         4'b0100: dec = 4'b0110;
         4'b1000: dec = 4'b0111;
         default: dec = 4'b1000;
      endcase
   endfunction

   function automatic logic [3:0] enc(input logic [1:0] v);
      enc = 4'b0001 << v;
   endfunction

   // R2/R3/R6 expected output digit with XOR
   function automatic logic [3:0] exp_q(input logic [3:0] a, input logic [3:0] b);
      logic [3:0] da, db;
      da = dec(a);
      db = dec(b);
      if (da[2] && db[2]) exp_q = enc(da[1:0] ^ db[1:0]);
      else                exp_q = 4'b0000;
   endfunction

   // R4/R5/R7 expected dual-rail output
   function automatic logic [1:0] exp_y(input logic [3:0] c);
      logic [3:0] dc;
      dc = dec(c);
      if (!dc[2])                exp_y = 2'b00;
      else if (dc[1] ^ dc[0])    exp_y = 2'b10;
      else                       exp_y = 2'b01;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic drive(input logic [L*4-1:0] a, input logic [L*4-1:0] b,
                        input logic [L*4-1:0] c);
      @(posedge clk);
      #1;
      a_dig = a;
      b_dig = b;
      c_dig = c;
      @(negedge clk);
   endtask

   // full per-lane check against the bench model
   task automatic check_all(input string req);
      for (int k = 0; k < L; k++) begin
         logic [3:0] ak, bk, ck;
         ak = a_dig[k*4 +: 4];
         bk = b_dig[k*4 +: 4];
         ck = c_dig[k*4 +: 4];
         chk({req, " q_dig"}, {4'b0, q_dig[k*4 +: 4]}, {4'b0, exp_q(ak, bk)});
         chk({req, " y_dr"}, {6'b0, y_dr[k*2 +: 2]}, {6'b0, exp_y(ck)});
         chk({req, " bw_err R6"}, {7'b0, bw_err[k]}, {7'b0, dec(ak)[3] | dec(bk)[3]});
         chk({req, " qb_err R7"}, {7'b0, qb_err[k]}, {7'b0, dec(ck)[3]});
      end
   endtask

   function automatic logic [3:0] rnd_dig();
      int r;
      r = int'($urandom % 10);
      if (r < 7)       rnd_dig = enc(2'($urandom));
      else if (r == 7) rnd_dig = 4'b0000;
      else             rnd_dig = 4'($urandom);
   endfunction

   initial begin
      a_dig = '0;
      b_dig = '0;
      c_dig = '0;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // idle state: all spacer in, all spacer out
      chk("R3 idle q_dig", {4'b0, q_dig[3:0]}, 8'h00);
      chk("R5 idle y_dr", {6'b0, y_dr}, 8'h00);
      chk("R6 idle bw_err", {6'b0, bw_err}, 8'h00);

      // R1 R2 R9: all 16 operand pairs on lane 0, lane 1 at spacer
      for (int i = 0; i < 4; i++) begin
         for (int j = 0; j < 4; j++) begin
            drive({4'b0000, enc(2'(i))}, {4'b0000, enc(2'(j))}, 8'h00);
            chk("R2 pair lane0", {4'b0, q_dig[3:0]}, {4'b0, enc(2'(i ^ j))});
            chk("R9 lane1 untouched", {4'b0, q_dig[7:4]}, 8'h00);
         end
      end

      // R4: all four quaternary-to-binary inputs
      for (int v = 0; v < 4; v++) begin
         drive(8'h00, 8'h00, {4'b0000, enc(2'(v))});
         chk("R4 qb lane0", {6'b0, y_dr[1:0]}, (v == 1 || v == 2) ? 8'h02 : 8'h01);
         chk("R9 qb lane1 spacer", {6'b0, y_dr[3:2]}, 8'h00);
      end

      // R3: one operand valid, the other spacer
      drive({4'b0000, 4'b0100}, 8'h00, 8'h00);
      chk("R3 A only", {4'b0, q_dig[3:0]}, 8'h00);
      drive(8'h00, {4'b1000, 4'b0010}, 8'h00);
      chk("R3 B only", {4'b0, q_dig}, 8'h00);

      // R6 / R7: multi-hot codes
      drive({4'b0001, 4'b0011}, {4'b0010, 4'b0001}, {4'b1111, 4'b0110});
      chk("R6 illegal A lane0", {4'b0, q_dig[3:0]}, 8'h00);
      chk("R6 err lane0", {7'b0, bw_err[0]}, 8'h01);
      chk("R6 lane1 valid", {4'b0, q_dig[7:4]}, {4'b0, enc(2'b01)});
      chk("R7 illegal qb", {4'b0, y_dr}, 8'h00);
      chk("R7 err", {6'b0, qb_err}, 8'h03);
      drive({4'b1111, 4'b0001}, {4'b0000, 4'b1100}, 8'h00);
      check_all("R6 illegal with spacer");

      // random mix
      for (int n = 0; n < 400; n++) begin
         drive({rnd_dig(), rnd_dig()}, {rnd_dig(), rnd_dig()}, {rnd_dig(), rnd_dig()});
         check_all("R8 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule